// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that finishes every instruction in the same clock cycle in which it is fetched. Instructions come from a read-only instruction memory. Loads and stores use a separate data memory. Both memories sit outside the block. The instruction port is combinational: the core drives an address, and the 32-bit word must return within the same cycle. The data port works the same way for reads. A data write takes effect at the rising clock edge.

The core decodes eight operations:
- five register-to-register operations: add, subtract, AND, OR and signed set-less-than;
- word load;
- word store;
- branch-if-equal.

Inside the block are the program counter, a 32-entry register file, the sign extender, the ALU, a separate adder that forms branch targets, and the multiplexers that steer operands and write-back. The decoder and the datapath are separate modules. They talk through one packed bundle of control strobes.

Top module: `mini_core`

## Requirements
- R1: While the synchronous reset is high, every rising edge loads the program counter with 0 and clears every register. The first fetch after reset is from address 0.
- R2: For every instruction other than branch-if-equal, and for a branch whose operands differ, the next program counter is the current one plus 4.
- R3: Branch-if-equal uses opcode 0x04 in bits 31:26. When the registers named by bits 25:21 and 20:16 hold equal values, the next program counter is the current one plus 4, plus the sign-extended bits 15:0 shifted left by 2. Both forward and backward offsets work.
- R4: Register operations use opcode 0x00. The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Set-less-than produces 1 or 0. The operands come from the registers named by bits 25:21 and 20:16. The result goes to the register named by bits 15:11.
- R5: A word load uses opcode 0x23. It raises the data read enable and drives the data address as the base register (bits 25:21) plus the sign-extended bits 15:0. It writes the returned word into the register named by bits 20:16, never into the one named by bits 15:11.
- R6: A word store uses opcode 0x2B. It raises the data write enable and drives the address the same way as a load. The write data is the register named by bits 20:16. A store writes no register.
- R7: Branch-if-equal raises neither data strobe and writes no register.
- R8: Register 0 always reads as zero. A write aimed at register 0 has no effect.
- R9: The data read and write enables are never high together. An unknown opcode, or opcode 0x00 with an unknown function code, writes no register and no memory, and the core moves on to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Byte address of the instruction being executed (the program counter) |
| imemData | input | 32 | Instruction word returned for imemAddr in the same cycle |
| dmemRe | output | 1 | Data read enable, high for a load |
| dmemWe | output | 1 | Data write enable, high for a store; the write happens at the rising edge |
| dmemAddr | output | 32 | Data byte address (ALU result) |
| dmemWdata | output | 32 | Store data |
| dmemRdata | input | 32 | Load data returned for dmemAddr in the same cycle |

## Verification
The assertions check, on every cycle, the rules visible at the ports:
- the program counter after reset;
- the plus-4 step after anything that is not a branch;
- that a branch lands on one of its two legal targets;
- that the two data strobes are exclusive and match the opcode;
- that register 0 reads as zero when used as a store source or as an address base.

Only the bench's program scenarios can show that the values reach the registers correctly:
- the ALU results;
- the signed comparison;
- load write-back to the right field;
- the dropped write to register 0;
- skipped stores under a taken branch;
- a backward loop that ends at the right count.

The bench shows these through later stores compared against a behavioural model every cycle.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

  localparam int INSN_W = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } aluFn_e;

  typedef struct packed {
    logic   regWrite;
    logic   dstFromRd;
    logic   immOperand;
    logic   memRead;
    logic   memWrite;
    logic   loadToReg;
    logic   branchEq;
    aluFn_e aluFn;
  } ctrlStrobes_t;

endpackage

// File: rtl/mini_core_ctrl.sv
module mini_core_ctrl
  import mini_core_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t strobes
);

  aluFn_e rFn;
  logic   rKnown;

  // Decode of the function code for register operations
  always_comb begin
    rKnown = 1'b1;
    rFn    = ALU_ADD;
    case (funct)
      FN_ADD:  rFn = ALU_ADD;
      FN_SUB:  rFn = ALU_SUB;
      FN_AND:  rFn = ALU_AND;
      FN_OR:   rFn = ALU_OR;
      FN_SLT:  rFn = ALU_SLT;
      default: rKnown = 1'b0;
    endcase
  end

  // Opcode decode; anything unknown falls through as a no-op (R9)
  always_comb begin
    strobes = '{regWrite: 1'b0, dstFromRd: 1'b0, immOperand: 1'b0,
                memRead: 1'b0, memWrite: 1'b0, loadToReg: 1'b0,
                branchEq: 1'b0, aluFn: ALU_ADD};
    case (opcode)
      OPC_ALU: begin
        strobes.regWrite  = rKnown;
        strobes.dstFromRd = 1'b1;
        strobes.aluFn     = rFn;
      end
      OPC_LOAD: begin
        strobes.regWrite   = 1'b1;
        strobes.immOperand = 1'b1;
        strobes.memRead    = 1'b1;
        strobes.loadToReg  = 1'b1;
      end
      OPC_STORE: begin
        strobes.immOperand = 1'b1;
        strobes.memWrite   = 1'b1;
      end
      OPC_BEQ: begin
        strobes.branchEq = 1'b1;
        strobes.aluFn    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mini_core_alu.sv
module mini_core_alu
  import mini_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluFn_e            fn,
  output logic [DATA_W-1:0] result,
  output logic              isZero
);

  logic lessSigned;
  assign lessSigned = $signed(opA) < $signed(opB);

  always_comb begin
    case (fn)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(DATA_W-1){1'b0}}, lessSigned};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/mini_core_regfile.sv
module mini_core_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regView [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gen_reg
    if (g == 0) begin : gen_zero
      assign regView[g] = '0;
    end else begin : gen_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
          q <= wrData;
        end
      end
      assign regView[g] = q;
    end
  end

  assign rdDataA = regView[rdAddrA];
  assign rdDataB = regView[rdAddrB];

endmodule

// File: rtl/mini_core_datapath.sv
module mini_core_datapath
  import mini_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] fieldRs,
  input  logic [REG_AW-1:0] fieldRt,
  input  logic [REG_AW-1:0] fieldRd,
  input  logic [IMM_W-1:0]  imm16,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int PC_STEP  = INSN_W / 8;
  localparam int OFF_SHFT = $clog2(PC_STEP);

  logic [DATA_W-1:0] rdA, rdB, immExt, aluB, aluY, wrData;
  logic [DATA_W-1:0] pcPlusStep, branchTarget, pcNext;
  logic [REG_AW-1:0] wrAddr;
  logic              aluZero, takeBranch;

  assign immExt = {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign aluB   = strobes.immOperand ? immExt : rdB;
  assign wrAddr = strobes.dstFromRd ? fieldRd : fieldRt;
  assign wrData = strobes.loadToReg ? memRdata : aluY;

  mini_core_regfile #(.DATA_W(DATA_W), .ADDR_W(REG_AW)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (fieldRs),
    .rdAddrB (fieldRt),
    .rdDataA (rdA),
    .rdDataB (rdB),
    .wrEn    (strobes.regWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  mini_core_alu #(.DATA_W(DATA_W)) i_alu (
    .opA    (rdA),
    .opB    (aluB),
    .fn     (strobes.aluFn),
    .result (aluY),
    .isZero (aluZero)
  );

  // Sequential and branch-target adders, kept apart from the ALU
  assign pcPlusStep   = pc + DATA_W'(PC_STEP);
  assign branchTarget = pcPlusStep + (immExt << OFF_SHFT);
  assign takeBranch   = strobes.branchEq & aluZero;
  assign pcNext       = takeBranch ? branchTarget : pcPlusStep;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else begin
      pc <= pcNext;
    end
  end

  assign memAddr  = aluY;
  assign memWdata = rdB;

endmodule

// File: rtl/mini_core.sv
module mini_core
  import mini_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imemAddr,
  input  logic [INSN_W-1:0] imemData,
  output logic              dmemRe,
  output logic              dmemWe,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  input  logic [DATA_W-1:0] dmemRdata
);

  ctrlStrobes_t strobes;

  mini_core_ctrl i_ctrl (
    .opcode  (imemData[31:26]),
    .funct   (imemData[5:0]),
    .strobes (strobes)
  );

  mini_core_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .fieldRs  (imemData[25:21]),
    .fieldRt  (imemData[20:16]),
    .fieldRd  (imemData[15:11]),
    .imm16    (imemData[15:0]),
    .strobes  (strobes),
    .pc       (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata),
    .memRdata (dmemRdata)
  );

  assign dmemRe = strobes.memRead;
  assign dmemWe = strobes.memWrite;

endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
  import mini_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] imemAddr,
  input logic [INSN_W-1:0] imemData,
  input logic              dmemRe,
  input logic              dmemWe,
  input logic [DATA_W-1:0] dmemAddr,
  input logic [DATA_W-1:0] dmemWdata
);

  logic [5:0]        opc;
  logic [DATA_W-1:0] immExt, brOff;

  assign opc    = imemData[31:26];
  assign immExt = {{(DATA_W-16){imemData[15]}}, imemData[15:0]};
  assign brOff  = {{(DATA_W-18){imemData[15]}}, imemData[15:0], 2'b00};

  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imemAddr == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (opc != OPC_BEQ) |=> (imemAddr == $past(imemAddr) + DATA_W'(4)));

  assert_branch_dest_R3: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BEQ) |=> ((imemAddr == $past(imemAddr) + DATA_W'(4)) ||
                          (imemAddr == $past(imemAddr) + DATA_W'(4) + $past(brOff))));

  assert_read_only_load_R5: assert property (@(posedge clk) disable iff (rst)
    dmemRe |-> (opc == OPC_LOAD));

  assert_write_only_store_R6: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> (opc == OPC_STORE));

  assert_branch_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BEQ) |-> (!dmemRe && !dmemWe));

  assert_zero_source_R8: assert property (@(posedge clk) disable iff (rst)
    ((opc == OPC_STORE) && (imemData[20:16] == '0)) |-> (dmemWdata == '0));

  assert_zero_base_R8: assert property (@(posedge clk) disable iff (rst)
    (((opc == OPC_STORE) || (opc == OPC_LOAD)) && (imemData[25:21] == '0))
      |-> (dmemAddr == immExt));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(dmemRe && dmemWe));

endmodule

bind mini_core mini_core_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .imemAddr  (imemAddr),
  .imemData  (imemData),
  .dmemRe    (dmemRe),
  .dmemWe    (dmemWe),
  .dmemAddr  (dmemAddr),
  .dmemWdata (dmemWdata)
);

// File: tb/test_mini_core.sv
`timescale 1ns/1ps
module test_mini_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemRe, dmemWe;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] mRegs [32];
  logic [31:0] mDmem [64];
  logic [31:0] mPc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  mini_core i_mini_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemRe(dmemRe), .dmemWe(dmemWe), .dmemAddr(dmemAddr),
    .dmemWdata(dmemWdata), .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];

  function automatic logic [31:0] initWord(int i);
    case (i)
      0: return 32'd5;
      1: return 32'hFFFF_FFFD;
      2: return 32'd7;
      3: return 32'h0F0F_00FF;
      10: return 32'h0000_DEAD;
      11: return 32'h1111_1111;
      14: return 32'h0000_BEEF;
      default: return 32'hA000_0000 + 32'(i);
    endcase
  endfunction

  // Bench memory: refilled while in reset, written by stores otherwise
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) dmem[i] <= initWord(i);
    end else if (dmemWe) begin
      dmem[dmemAddr[7:2]] <= dmemWdata;
    end
  end

  function automatic logic [31:0] rOp(logic [5:0] fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iOp(logic [5:0] op, int rt, int rs, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: compare ports for the current instruction, then advance
  task automatic stepModel();
    logic [31:0] ins, a, b, ea, res, nxt;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          wr, known;
    string       tag;
    ins = imem[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mRegs[rs]; b = mRegs[rt];
    ea = a + {{16{ins[15]}}, ins[15:0]};
    nxt = mPc + 4;
    known = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04);
    tag = (op == 6'h04) ? "R3 pc" : "R2 pc";
    check(tag, imemAddr, mPc);
    tag = (op == 6'h04) ? "R7 strobe" : (known ? "R5/R6 strobe" : "R9 strobe");
    check({tag, " re"}, 32'(dmemRe), 32'(op == 6'h23));
    check({tag, " we"}, 32'(dmemWe), 32'(op == 6'h2B));
    if (op == 6'h23) check("R5 load address", dmemAddr, ea);
    if (op == 6'h2B) begin
      check("R6 store address", dmemAddr, ea);
      check("R6 store data", dmemWdata, b);
    end
    wr = 0; res = '0;
    case (op)
      6'h00: begin
        wr = 1;
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wr = 0;
        endcase
        if (wr && rd != 0) mRegs[rd] = res;
      end
      6'h23: if (rt != 0) mRegs[rt] = mDmem[ea[7:2]];
      6'h2B: mDmem[ea[7:2]] = b;
      6'h04: if (a == b) nxt = mPc + 4 + {{14{ins[15]}}, ins[15:0], 2'b00};
      default: ;
    endcase
    mPc = nxt;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = '0;
    imem[0]  = iOp(6'h23, 1, 0, 0);
    imem[1]  = iOp(6'h23, 2, 0, 4);
    imem[2]  = iOp(6'h23, 3, 0, 8);
    imem[3]  = iOp(6'h23, 4, 0, 12);
    imem[4]  = rOp(6'h20, 5, 1, 3);
    imem[5]  = rOp(6'h22, 6, 1, 3);
    imem[6]  = rOp(6'h24, 7, 4, 3);
    imem[7]  = rOp(6'h25, 8, 1, 2);
    imem[8]  = rOp(6'h2A, 9, 2, 1);
    imem[9]  = rOp(6'h2A, 10, 1, 2);
    imem[10] = rOp(6'h20, 0, 1, 1);
    imem[11] = iOp(6'h2B, 5, 0, 16);
    imem[12] = iOp(6'h2B, 6, 0, 20);
    imem[13] = iOp(6'h2B, 7, 0, 24);
    imem[14] = iOp(6'h2B, 8, 0, 28);
    imem[15] = iOp(6'h2B, 9, 0, 32);
    imem[16] = iOp(6'h2B, 10, 0, 36);
    imem[17] = iOp(6'h2B, 0, 0, 40);
    imem[18] = iOp(6'h04, 3, 1, 5);
    imem[19] = iOp(6'h23, 11, 5, -4);
    imem[20] = iOp(6'h04, 3, 11, 2);
    imem[21] = iOp(6'h2B, 1, 0, 44);
    imem[22] = iOp(6'h2B, 1, 0, 44);
    imem[23] = rOp(6'h20, 15, 1, 1);
    imem[24] = rOp(6'h20, 15, 15, 1);
    imem[25] = rOp(6'h20, 12, 0, 0);
    imem[26] = rOp(6'h20, 12, 12, 1);
    imem[27] = iOp(6'h04, 15, 12, 1);
    imem[28] = iOp(6'h04, 0, 0, -3);
    imem[29] = iOp(6'h2B, 12, 0, 48);
    imem[30] = iOp(6'h3F, 1, 0, 48);
    imem[31] = rOp(6'h3F, 1, 2, 3);
    imem[32] = iOp(6'h2B, 1, 0, 52);
    imem[33] = iOp(6'h2B, 31, 0, 56);
    imem[34] = iOp(6'h04, 0, 0, -1);

    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    for (int i = 0; i < 64; i++) mDmem[i] = initWord(i);
    mPc = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset pc", imemAddr, 32'd0);
    for (int c = 0; c < 70; c++) begin
      stepModel();
      @(negedge clk);
    end

    check("R4 add",            dmem[4],  32'd12);
    check("R4 sub",            dmem[5],  32'hFFFF_FFFE);
    check("R4 and",            dmem[6],  32'd7);
    check("R4 or",             dmem[7],  32'hFFFF_FFFD);
    check("R4 slt true",       dmem[8],  32'd1);
    check("R4 slt false",      dmem[9],  32'd0);
    check("R8 r0 stays zero",  dmem[10], 32'd0);
    check("R3 skipped store",  dmem[11], 32'h1111_1111);
    check("R3 backward loop",  dmem[12], 32'd15);
    check("R9 unknown no-op",  dmem[13], 32'd5);
    check("R5 rt destination", dmem[14], 32'd0);

    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc after reset", imemAddr, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule